// File: doc/BRIEF.md
# Two-Master Fixed-Priority AHB-Lite Slave Sharer

This block lets several AHB-Lite masters (two by default) reach a single AHB-Lite slave. Whenever the slave can take a new address phase, the block picks the requesting master with the smallest port index and forwards its address phase. A master that loses is not refused. The block takes its address phase anyway, parks it in a per-port holding register, and stalls that master with wait states. The parked address is replayed to the slave once that port wins.

An incrementing burst can be cut in two when a higher-priority master steps in. In that case the rest of the burst is sent to the slave as a new burst. Its first beat goes out as NONSEQ, and its burst code is computed from the number of beats still to come. Each port keeps a count of its remaining beats for this purpose. The data phase is routed by a registered owner index. Write data is taken from that owner, and the slave's ready and response go only to that owner. Wrapping bursts, BUSY transfers, locking, protection attributes and error generation are not handled.

Top module: `ahbarb_fixed_prio`

## Requirements
- R1: When more than one port has an address phase ready in a cycle where the slave is ready, the port with the lowest index is forwarded.
- R2: A port whose address phase was taken from the master but not forwarded to the slave drives its HREADYOUT low (0) from the next cycle until the parked transfer has been forwarded and its data phase has finished.
- R3: Once a burst of the lowest-index port has started, no beat of another port reaches the slave before that burst's last beat.
- R4: The first beat that a port forwards after another port has used the slave is driven with HTRANS = NONSEQ (2'b10), even when the master presented SEQ (2'b11).
- R5: On such a restart, the forwarded HBURST encodes the remaining beat count n, including the restart beat: 1 gives SINGLE (0), 4 gives INCR4 (3), 8 gives INCR8 (5), 16 gives INCR16 (7), and any other count or an undefined-length burst gives INCR (1).
- R6: The slave's HREADY and HRESP are presented only to the port that owns the data phase in progress. Every other port sees its own HREADYOUT: low if it has a parked transfer, high otherwise.
- R7: Write data forwarded to the slave is taken from the data-phase owner, and the owner receives the slave's read data in the cycle its data phase completes.
- R8: Every beat a master issues reaches the slave exactly once, in issue order, with its own address, direction and size. None is lost, duplicated or misaddressed.
- R9: During and right after reset, every port's HREADYOUT is high and the slave sees HTRANS = IDLE.
- R10: A burst that is not interrupted passes to the slave with its original HTRANS and HBURST. The SEQ beats that follow a restart carry the re-encoded HBURST of that restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_haddr | input | NUM_M x ADDR_W | Master address per port |
| m_htrans | input | NUM_M x 2 | Master transfer type per port |
| m_hwrite | input | NUM_M | Master write flag per port |
| m_hsize | input | NUM_M x 3 | Master transfer size per port |
| m_hburst | input | NUM_M x 3 | Master burst type per port |
| m_hwdata | input | NUM_M x DATA_W | Master write data per port |
| m_hrdata | output | NUM_M x DATA_W | Read data returned to each port |
| m_hreadyout | output | NUM_M | Ready returned to each port |
| m_hresp | output | NUM_M | Response returned to each port |
| s_haddr | output | ADDR_W | Forwarded address |
| s_htrans | output | 2 | Forwarded transfer type |
| s_hwrite | output | 1 | Forwarded write flag |
| s_hsize | output | 3 | Forwarded size |
| s_hburst | output | 3 | Forwarded (possibly re-encoded) burst type |
| s_hwdata | output | DATA_W | Write data of the data-phase owner |
| s_hrdata | input | DATA_W | Slave read data |
| s_hready | input | 1 | Slave ready |
| s_hresp | input | 1 | Slave response |

## Verification
A corrupted holding register or remaining-beat counter shows up at the slave port in the very cycle the parked beat is replayed: the address is wrong, or the HTRANS or HBURST code differs from what the remaining count implies. A wrong data-phase owner is visible in the same cycle as HREADYOUT mismatching the slave's ready on the owning port. It also surfaces one cycle later as wrong read data or as write data landing on another master's address. The reference model therefore compares every forwarded beat against per-master queues, and it compares the ready of the owner and of any stalled port on every clock.

// File: rtl/ahbarb_pkg.sv
package ahbarb_pkg;

  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic [1:0] HT_SEQ    = 2'b11;

  localparam logic [2:0] HB_SINGLE = 3'd0;
  localparam logic [2:0] HB_INCR   = 3'd1;
  localparam logic [2:0] HB_INCR4  = 3'd3;
  localparam logic [2:0] HB_INCR8  = 3'd5;
  localparam logic [2:0] HB_INCR16 = 3'd7;

  localparam int BEAT_W = 5;

  // Beat count of a fixed-length burst code; 0 marks an undefined length.
  function automatic logic [BEAT_W-1:0] beats_of(input logic [2:0] hb);
    logic [BEAT_W-1:0] n;
    case (hb)
      3'd0:       n = BEAT_W'(1);
      3'd2, 3'd3: n = BEAT_W'(4);
      3'd4, 3'd5: n = BEAT_W'(8);
      3'd6, 3'd7: n = BEAT_W'(16);
      default:    n = '0;
    endcase
    return n;
  endfunction

  // Burst code describing n outstanding beats; exact matches only.
  function automatic logic [2:0] code_for(input logic [BEAT_W-1:0] n, input logic open);
    logic [2:0] c;
    if (open) c = HB_INCR;
    else begin
      case (n)
        BEAT_W'(1):  c = HB_SINGLE;
        BEAT_W'(4):  c = HB_INCR4;
        BEAT_W'(8):  c = HB_INCR8;
        BEAT_W'(16): c = HB_INCR16;
        default:     c = HB_INCR;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/ahbarb_req_slot.sv
module ahbarb_req_slot
  import ahbarb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [2:0]        hburst,
  input  logic              hready_seen,
  input  logic              accept,
  input  logic              owns_bus,
  output logic              req,
  output logic              held,
  output logic [ADDR_W-1:0] f_addr,
  output logic [1:0]        f_trans,
  output logic              f_write,
  output logic [2:0]        f_size,
  output logic [2:0]        f_burst
);

  logic              live;
  logic [ADDR_W-1:0] pk_addr;
  logic [1:0]        pk_trans;
  logic              pk_write;
  logic [2:0]        pk_size;
  logic [2:0]        pk_burst;

  logic [ADDR_W-1:0] src_addr;
  logic [1:0]        src_trans;
  logic              src_write;
  logic [2:0]        src_size;
  logic [2:0]        src_burst;

  logic [BEAT_W-1:0] left;
  logic              open_len;
  logic [2:0]        cur_burst;
  logic              restart;

  // A live address phase is only sampled while this port sees ready high.
  assign live = hready_seen & htrans[1];
  assign req  = held | live;

  always_comb begin
    if (held) begin
      src_addr  = pk_addr;
      src_trans = pk_trans;
      src_write = pk_write;
      src_size  = pk_size;
      src_burst = pk_burst;
    end else begin
      src_addr  = haddr;
      src_trans = htrans;
      src_write = hwrite;
      src_size  = hsize;
      src_burst = hburst;
    end
  end

  assign restart = (src_trans == HT_SEQ) && !owns_bus;

  always_comb begin
    f_addr  = src_addr;
    f_write = src_write;
    f_size  = src_size;
    f_trans = restart ? HT_NONSEQ : src_trans;
    if (src_trans == HT_NONSEQ) f_burst = src_burst;
    else if (restart)           f_burst = code_for(left, open_len);
    else                        f_burst = cur_burst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= 1'b0;
      pk_addr   <= '0;
      pk_trans  <= HT_IDLE;
      pk_write  <= 1'b0;
      pk_size   <= '0;
      pk_burst  <= HB_SINGLE;
      left      <= '0;
      open_len  <= 1'b0;
      cur_burst <= HB_SINGLE;
    end else begin
      if (live && !accept) begin
        held     <= 1'b1;
        pk_addr  <= haddr;
        pk_trans <= htrans;
        pk_write <= hwrite;
        pk_size  <= hsize;
        pk_burst <= hburst;
      end else if (accept) begin
        held <= 1'b0;
      end
      if (accept) begin
        cur_burst <= f_burst;
        if (src_trans == HT_NONSEQ) begin
          left     <= beats_of(src_burst) - BEAT_W'(1);
          open_len <= (beats_of(src_burst) == '0);
        end else if (!open_len) begin
          left <= left - BEAT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/ahbarb_prio_pick.sv
module ahbarb_prio_pick #(
  parameter int NUM_M = 2,
  parameter int IDX_W = 1
) (
  input  logic [NUM_M-1:0] req,
  input  logic             enable,
  output logic [NUM_M-1:0] grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  // Scan from the top so the lowest requesting index is the last writer.
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    if (enable) begin
      for (int i = NUM_M - 1; i >= 0; i--) begin
        if (req[i]) begin
          grant    = '0;
          grant[i] = 1'b1;
          idx      = IDX_W'(i);
          any      = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ahbarb_dphase.sv
module ahbarb_dphase #(
  parameter int NUM_M  = 2,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         s_hready,
  input  logic                         s_hresp,
  input  logic [DATA_W-1:0]            s_hrdata,
  input  logic                         any,
  input  logic [IDX_W-1:0]             idx,
  input  logic [NUM_M-1:0]             held,
  input  logic [NUM_M-1:0][DATA_W-1:0] m_hwdata,
  output logic [NUM_M-1:0][DATA_W-1:0] m_hrdata,
  output logic [NUM_M-1:0]             m_hreadyout,
  output logic [NUM_M-1:0]             m_hresp,
  output logic [DATA_W-1:0]            s_hwdata,
  output logic [NUM_M-1:0]             owns,
  output logic                         dp_valid,
  output logic [IDX_W-1:0]             dp_owner
);

  logic             last_v;
  logic [IDX_W-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_valid <= 1'b0;
      dp_owner <= '0;
      last_v   <= 1'b0;
      last_idx <= '0;
    end else if (s_hready) begin
      dp_valid <= any;
      if (any) begin
        dp_owner <= idx;
        last_idx <= idx;
        last_v   <= 1'b1;
      end
    end
  end

  assign s_hwdata = m_hwdata[dp_owner];

  for (genvar g = 0; g < NUM_M; g++) begin : g_ret
    logic mine;
    assign mine           = dp_valid && (dp_owner == IDX_W'(g));
    assign m_hreadyout[g] = mine ? s_hready : !held[g];
    assign m_hresp[g]     = mine ? s_hresp : 1'b0;
    assign m_hrdata[g]    = s_hrdata;
    assign owns[g]        = last_v && (last_idx == IDX_W'(g));
  end

endmodule

// File: rtl/ahbarb_fixed_prio.sv
module ahbarb_fixed_prio
  import ahbarb_pkg::*;
#(
  parameter int NUM_M  = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_M-1:0][ADDR_W-1:0] m_haddr,
  input  logic [NUM_M-1:0][1:0]        m_htrans,
  input  logic [NUM_M-1:0]             m_hwrite,
  input  logic [NUM_M-1:0][2:0]        m_hsize,
  input  logic [NUM_M-1:0][2:0]        m_hburst,
  input  logic [NUM_M-1:0][DATA_W-1:0] m_hwdata,
  output logic [NUM_M-1:0][DATA_W-1:0] m_hrdata,
  output logic [NUM_M-1:0]             m_hreadyout,
  output logic [NUM_M-1:0]             m_hresp,
  output logic [ADDR_W-1:0]            s_haddr,
  output logic [1:0]                   s_htrans,
  output logic                         s_hwrite,
  output logic [2:0]                   s_hsize,
  output logic [2:0]                   s_hburst,
  output logic [DATA_W-1:0]            s_hwdata,
  input  logic [DATA_W-1:0]            s_hrdata,
  input  logic                         s_hready,
  input  logic                         s_hresp
);

  localparam int IDX_W = (NUM_M > 1) ? $clog2(NUM_M) : 1;

  logic [NUM_M-1:0]             req;
  logic [NUM_M-1:0]             held;
  logic [NUM_M-1:0]             grant;
  logic [NUM_M-1:0]             owns;
  logic [IDX_W-1:0]             idx;
  logic                         any;
  logic                         dp_valid;
  logic [IDX_W-1:0]             dp_owner;
  logic [NUM_M-1:0][ADDR_W-1:0] f_addr;
  logic [NUM_M-1:0][1:0]        f_trans;
  logic [NUM_M-1:0]             f_write;
  logic [NUM_M-1:0][2:0]        f_size;
  logic [NUM_M-1:0][2:0]        f_burst;

  for (genvar g = 0; g < NUM_M; g++) begin : g_slot
    ahbarb_req_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk         (clk),
      .rst         (rst),
      .haddr       (m_haddr[g]),
      .htrans      (m_htrans[g]),
      .hwrite      (m_hwrite[g]),
      .hsize       (m_hsize[g]),
      .hburst      (m_hburst[g]),
      .hready_seen (m_hreadyout[g]),
      .accept      (grant[g]),
      .owns_bus    (owns[g]),
      .req         (req[g]),
      .held        (held[g]),
      .f_addr      (f_addr[g]),
      .f_trans     (f_trans[g]),
      .f_write     (f_write[g]),
      .f_size      (f_size[g]),
      .f_burst     (f_burst[g])
    );
  end

  ahbarb_prio_pick #(.NUM_M(NUM_M), .IDX_W(IDX_W)) u_pick (
    .req    (req),
    .enable (s_hready),
    .grant  (grant),
    .idx    (idx),
    .any    (any)
  );

  ahbarb_dphase #(.NUM_M(NUM_M), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dph (
    .clk         (clk),
    .rst         (rst),
    .s_hready    (s_hready),
    .s_hresp     (s_hresp),
    .s_hrdata    (s_hrdata),
    .any         (any),
    .idx         (idx),
    .held        (held),
    .m_hwdata    (m_hwdata),
    .m_hrdata    (m_hrdata),
    .m_hreadyout (m_hreadyout),
    .m_hresp     (m_hresp),
    .s_hwdata    (s_hwdata),
    .owns        (owns),
    .dp_valid    (dp_valid),
    .dp_owner    (dp_owner)
  );

  always_comb begin
    s_haddr  = f_addr[idx];
    s_hwrite = f_write[idx];
    s_hsize  = f_size[idx];
    s_hburst = f_burst[idx];
    s_htrans = any ? f_trans[idx] : HT_IDLE;
  end

endmodule

// File: rtl/ahbarb_fixed_prio_chk.sv
module ahbarb_fixed_prio_chk
  import ahbarb_pkg::*;
#(
  parameter int NUM_M = 2,
  parameter int IDX_W = 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_M-1:0]      m_hreadyout,
  input logic [NUM_M-1:0][1:0] m_htrans,
  input logic                  s_hready,
  input logic [1:0]            s_htrans,
  input logic [NUM_M-1:0]      req,
  input logic [NUM_M-1:0]      grant,
  input logic                  dp_valid,
  input logic [IDX_W-1:0]      dp_owner
);

  logic [IDX_W-1:0] gidx;
  logic [IDX_W-1:0] seen_idx;
  logic             seen_v;

  always_comb begin
    gidx = '0;
    for (int i = 0; i < NUM_M; i++) if (grant[i]) gidx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_v   <= 1'b0;
      seen_idx <= '0;
    end else if (s_hready && s_htrans[1]) begin
      seen_v   <= 1'b1;
      seen_idx <= gidx;
    end
  end

  a_r1_low_index_wins: assert property (@(posedge clk) disable iff (rst)
    (s_hready && req[0]) |-> grant[0]);

  a_r8_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r4_seq_needs_same_owner: assert property (@(posedge clk) disable iff (rst)
    (s_hready && s_htrans == HT_SEQ) |-> (seen_v && gidx == seen_idx));

  a_r6_ready_to_owner: assert property (@(posedge clk) disable iff (rst)
    dp_valid |-> (m_hreadyout[dp_owner] == s_hready));

  for (genvar g = 0; g < NUM_M; g++) begin : g_stall
    a_r2_refused_stalls: assert property (@(posedge clk) disable iff (rst)
      (m_hreadyout[g] && m_htrans[g][1] && !grant[g]) |=> !m_hreadyout[g]);
  end

endmodule

bind ahbarb_fixed_prio ahbarb_fixed_prio_chk #(.NUM_M(NUM_M), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .m_hreadyout (m_hreadyout),
  .m_htrans    (m_htrans),
  .s_hready    (s_hready),
  .s_htrans    (s_htrans),
  .req         (req),
  .grant       (grant),
  .dp_valid    (dp_valid),
  .dp_owner    (dp_owner)
);

// File: tb/ahbarb_fixed_prio_tb.sv
module ahbarb_fixed_prio_tb;

  localparam int NM = 2;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NM-1:0][AW-1:0] m_haddr;
  logic [NM-1:0][1:0]    m_htrans;
  logic [NM-1:0]         m_hwrite;
  logic [NM-1:0][2:0]    m_hsize;
  logic [NM-1:0][2:0]    m_hburst;
  logic [NM-1:0][DW-1:0] m_hwdata;
  logic [NM-1:0][DW-1:0] m_hrdata;
  logic [NM-1:0]         m_hreadyout;
  logic [NM-1:0]         m_hresp;
  logic [AW-1:0]         s_haddr;
  logic [1:0]            s_htrans;
  logic                  s_hwrite;
  logic [2:0]            s_hsize;
  logic [2:0]            s_hburst;
  logic [DW-1:0]         s_hwdata;
  logic [DW-1:0]         s_hrdata = '0;
  logic                  s_hready = 1'b1;
  logic                  s_hresp  = 1'b0;

  ahbarb_fixed_prio #(.NUM_M(NM), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .m_haddr(m_haddr), .m_htrans(m_htrans), .m_hwrite(m_hwrite),
    .m_hsize(m_hsize), .m_hburst(m_hburst), .m_hwdata(m_hwdata),
    .m_hrdata(m_hrdata), .m_hreadyout(m_hreadyout), .m_hresp(m_hresp),
    .s_haddr(s_haddr), .s_htrans(s_htrans), .s_hwrite(s_hwrite),
    .s_hsize(s_hsize), .s_hburst(s_hburst), .s_hwdata(s_hwdata),
    .s_hrdata(s_hrdata), .s_hready(s_hready), .s_hresp(s_hresp)
  );

  typedef struct {
    logic [31:0] a;
    logic [2:0]  ob;
    int          rem;
    bit          first;
    bit          wr;
  } beat_t;

  beat_t       expq [NM][$];
  int          order_q[$];
  logic [31:0] mem  [logic [31:0]];
  logic [31:0] wexp [logic [31:0]];
  int          m_acc [NM];
  int          s_fwd [NM];
  logic [2:0]  cur_b [NM];
  int          last_port = -1;
  int          restarts = 0;
  bit          wait_mode = 0;
  bit          done = 0;
  int          nchk = 0;
  int          nfail = 0;

  function automatic logic [31:0] rfun(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction
  function automatic logic [31:0] wfun(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  function automatic logic [31:0] rexp(input logic [31:0] a);
    return wexp.exists(a) ? wexp[a] : rfun(a);
  endfunction
  function automatic logic [2:0] exp_code(input int r);
    if (r == 16) return 3'd7;
    if (r == 8)  return 3'd5;
    if (r == 4)  return 3'd3;
    if (r == 1)  return 3'd0;
    return 3'd1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pipelined master model: one address per accepted cycle, no BUSY.
  task automatic run_burst(input int p, input logic [31:0] base, input int n,
                           input logic [2:0] hb, input bit wr);
    logic [31:0] pa;
    bit pv;
    bit pw;
    int k;
    pv = 0; pw = 0; pa = '0; k = 0;
    for (int j = 0; j < n; j++) begin
      beat_t e;
      e.a = base + 32'(4 * j);
      e.ob = hb;
      e.first = (j == 0);
      e.wr = wr;
      e.rem = (hb == 3'd1) ? -1 : n - j;
      expq[p].push_back(e);
      if (wr) wexp[e.a] = wfun(e.a);
    end
    while (k < n || pv) begin
      if (k < n) begin
        m_haddr[p]  = base + 32'(4 * k);
        m_htrans[p] = (k == 0) ? 2'b10 : 2'b11;
        m_hwrite[p] = wr;
        m_hsize[p]  = 3'd2;
        m_hburst[p] = hb;
      end else begin
        m_htrans[p] = 2'b00;
      end
      m_hwdata[p] = (pv && pw) ? wfun(pa) : '0;
      @(negedge clk);
      if (m_hreadyout[p]) begin
        if (pv && !pw) chk(m_hrdata[p] == rexp(pa), "R7 read data", m_hrdata[p], rexp(pa));
        if (k < n) begin
          pa = base + 32'(4 * k); pw = wr; pv = 1; k++;
          m_acc[p]++;
        end else pv = 0;
      end
      @(posedge clk); #1;
    end
  endtask

  // Slave model plus forwarded-beat reference comparison.
  initial begin
    bit dv;
    bit dw;
    int dp;
    int wl;
    int nacc;
    logic [31:0] da;
    dv = 0; dw = 0; dp = 0; wl = 0; nacc = 0; da = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (dv) chk(m_hreadyout[dp] == s_hready, "R6 owner ready", {63'd0, m_hreadyout[dp]}, {63'd0, s_hready});
        if (s_hready) begin
          if (dv && dw) mem[da] = s_hwdata;
          dv = 0;
          if (s_htrans[1]) begin
            int p;
            p = int'(s_haddr[12]);
            if (expq[p].size() == 0) begin
              chk(0, "R8 unexpected beat", s_haddr, 0);
            end else begin
              beat_t e;
              bit rs;
              logic [1:0] et;
              logic [2:0] eb;
              e = expq[p].pop_front();
              rs = !e.first && (last_port != p);
              et = (e.first || rs) ? 2'b10 : 2'b11;
              eb = e.first ? e.ob : (rs ? exp_code(e.rem) : cur_b[p]);
              if (rs) restarts++;
              chk(s_haddr == e.a, "R8 address", s_haddr, e.a);
              chk(s_hwrite == e.wr && s_hsize == 3'd2, "R8 dir/size", {s_hwrite, s_hsize}, {e.wr, 3'd2});
              chk(s_htrans == et, rs ? "R4 restart htrans" : "R10 htrans", s_htrans, et);
              chk(s_hburst == eb, rs ? "R5 restart hburst" : "R10 hburst", s_hburst, eb);
              cur_b[p] = eb;
            end
            last_port = p;
            s_fwd[p]++;
            order_q.push_back(p);
            dv = 1; da = s_haddr; dw = s_hwrite; dp = p; nacc++;
            wl = (wait_mode && (nacc % 3 == 1)) ? 2 : 0;
          end
        end
      end
      @(posedge clk); #1;
      if (dv && wl > 0) begin s_hready = 1'b0; wl--; end
      else s_hready = 1'b1;
      s_hrdata = dv ? (mem.exists(da) ? mem[da] : rfun(da)) : '0;
    end
  end

  // Parked transfers must hold their master in wait states.
  always @(posedge clk) begin
    #5;
    if (!rst) begin
      for (int p = 0; p < NM; p++)
        if (m_acc[p] > s_fwd[p])
          chk(m_hreadyout[p] == 1'b0, "R2 stalled ready", {63'd0, m_hreadyout[p]}, 0);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int r0;
    for (int p = 0; p < NM; p++) begin
      m_haddr[p] = '0; m_htrans[p] = 2'b00; m_hwrite[p] = 0;
      m_hsize[p] = 3'd2; m_hburst[p] = 3'd0; m_hwdata[p] = '0;
      m_acc[p] = 0; s_fwd[p] = 0; cur_b[p] = 3'd0;
    end
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_hreadyout == 2'b11, "R9 ready in reset", m_hreadyout, 2'b11);
    chk(s_htrans == 2'b00, "R9 idle in reset", s_htrans, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(m_hreadyout == 2'b11, "R9 ready after reset", m_hreadyout, 2'b11);
    chk(s_htrans == 2'b00, "R9 idle after reset", s_htrans, 0);
    @(posedge clk); #1;

    // Lone bursts on each port.
    run_burst(0, 32'h0100, 4, 3'd3, 1);
    run_burst(1, 32'h1200, 8, 3'd5, 0);
    run_burst(0, 32'h0100, 4, 3'd3, 0);
    idle(2);

    // Simultaneous start: port 0 must go first and stay whole (R1, R3).
    order_q.delete();
    fork
      run_burst(0, 32'h0040, 4, 3'd3, 0);
      run_burst(1, 32'h1400, 8, 3'd5, 1);
    join
    idle(2);
    chk(order_q.size() == 12, "R8 beat count", order_q.size(), 12);
    for (int i = 0; i < 4; i++)
      chk(order_q[i] == 0, "R1 R3 port0 first and unsplit", order_q[i], 0);

    // Port 1 interrupted in the middle of a long burst (R4, R5).
    r0 = restarts;
    fork
      run_burst(1, 32'h1800, 16, 3'd7, 1);
      begin idle(8); run_burst(0, 32'h0300, 8, 3'd5, 1); end
    join
    idle(2);
    chk(restarts > r0, "R4 restart seen", restarts, r0 + 1);

    // Wait states, undefined length and single transfers.
    wait_mode = 1;
    r0 = restarts;
    fork
      run_burst(1, 32'h1a00, 6, 3'd1, 0);
      begin idle(3); run_burst(0, 32'h0380, 1, 3'd0, 1); run_burst(0, 32'h0100, 4, 3'd3, 0); end
    join
    idle(2);
    fork
      run_burst(1, 32'h1c00, 8, 3'd5, 1);
      begin idle(2); run_burst(0, 32'h03c0, 4, 3'd3, 1); end
    join
    idle(2);
    fork
      run_burst(1, 32'h1e00, 16, 3'd7, 0);
      begin idle(5); run_burst(0, 32'h0500, 4, 3'd3, 0); end
    join
    idle(4);
    chk(restarts > r0, "R5 restart with waits", restarts, r0 + 1);

    for (int p = 0; p < NM; p++)
      chk(expq[p].size() == 0, "R8 no lost beat", expq[p].size(), 0);
    foreach (wexp[a])
      chk(mem.exists(a) && mem[a] == wexp[a], "R7 write data", mem.exists(a) ? mem[a] : 32'hDEAD, wexp[a]);
    finish_run();
  end

endmodule